// File: doc/BRIEF.md
# Banked Debug Bus Comparator

This block holds three bus-access comparators, called A, B and C, for an on-chip debug unit. Each comparator watches CPU bus accesses and raises a one-cycle match pulse when the access address agrees with that comparator's reference address. The match can also require a given access direction (read or write) and a given access size (byte or word). The reference addresses come from address registers outside this block. This block owns only the three 8-bit control registers and the match logic.

The three control registers share one register offset, 0x28. A 2-bit bank select input picks which comparator's control register is read or written there. While the debug unit is armed, all control writes are refused. This keeps the match setup fixed during a capture. Comparators A and B can also invert the address test, so that any address other than the reference counts as a hit.

Top module: `dbg_cmp_bank`

## Requirements
- R1: After reset every control register reads 0x00 and no match output is asserted for any bus access.
- R2: At register offset 0x28, bank select 00, 01 and 10 reach the control register of comparator A, B and C for both reads and writes. Writes take effect on the next clock. Reads at any other offset return 0x00, and writes there change no control register.
- R3: While `armed` is 1, a write to the banked control register changes nothing. The same write made with `armed` at 0 is stored.
- R4: Bank select 11 reaches no comparator. Reads return 0x00 and writes leave all three control registers unchanged.
- R5: Control bit layout is bit7 size-compare enable, bit6 size value, bit5 tag, bit4 break, bit3 direction value, bit2 direction-compare enable, bit1 invert-address, bit0 comparator enable. All eight bits are stored for A and B. For C, bit1 always reads 0, and C always uses plain address equality.
- R6: The match for a comparator is asserted in the cycle after a valid bus access only when its enable bit is 1 and the access address equals its reference address. It lasts one cycle for a single access.
- R7: For A and B with bit1 set, the address test is inverted: an address that differs from the reference matches, and the reference address itself does not.
- R8: With bit2 set, a match also requires `bus_rnw` (1 = read) to equal bit3. With bit2 clear, the direction is ignored.
- R9: With bit7 set, a match requires the access size to equal bit6, where 0 means word (`bus_byte` = 0) and 1 means byte (`bus_byte` = 1). With bit7 clear, size and bit6 are ignored.
- R10: When bit5 (tag) is set, bit7 and bit6 are both ignored, and accesses of either size can match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 8 | Register offset of the access |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| bank_sel | input | 2 | Selects comparator A, B or C at the banked offset |
| reg_rdata | output | 8 | Read data of the addressed register (combinational) |
| armed | input | 1 | Debug unit armed; blocks control writes |
| cmp_ref | input | 48 | Reference addresses, A in bits 15:0, B in 31:16, C in 47:32 |
| bus_valid | input | 1 | A bus access is present this cycle |
| bus_addr | input | 16 | Bus access address |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| match | output | 3 | Registered match pulses, bit0 A, bit1 B, bit2 C |

## Verification
The hardest conditions to reach are those where two control bits interact. One is the tag bit overriding a size-compare setup that would otherwise reject the access. Another is comparator C being given the invert-address bit it does not implement. The stimulus reaches both by writing full control bytes through the banked window and then issuing accesses whose size or address is the one the ignored bit would have rejected. Write locking is checked by arming the unit, writing, disarming and reading the register back before any other write.

// File: rtl/dbg_cmp_pkg.sv
package dbg_cmp_pkg;
  localparam int CTL_W   = 8;
  localparam int NCMP    = 3;
  localparam int SEL_W   = 2;
  localparam int NDB_CNT = 2;
  localparam logic [7:0] CTL_OFFSET = 8'h28;

  typedef struct packed {
    logic sz_en;
    logic sz_val;
    logic tag;
    logic brk;
    logic dir_val;
    logic dir_en;
    logic inv_addr;
    logic en;
  } cmp_ctl_t;
endpackage

// File: rtl/dbg_rst_sync.sv
module dbg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/dbg_cmp_ctl_reg.sv
module dbg_cmp_ctl_reg
  import dbg_cmp_pkg::*;
#(
  parameter bit HAS_INV = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel,
  input  logic             armed,
  input  logic [CTL_W-1:0] wdata,
  output cmp_ctl_t         ctl
);
  localparam logic [CTL_W-1:0] WMASK = HAS_INV ? 8'hFF : 8'hFD;

  cmp_ctl_t ctl_q;
  cmp_ctl_t ctl_d;
  logic     ld;

  assign ld = wr_sel & ~armed;

  always_comb begin
    ctl_d = ctl_q;
    if (ld) ctl_d = cmp_ctl_t'(wdata & WMASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (ld) ctl_q <= ctl_d;
  end

  assign ctl = ctl_q;

  // R3
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && armed) |=> $stable(ctl_q));
endmodule

// File: rtl/dbg_cmp_match.sv
module dbg_cmp_match #(
  parameter int ADDR_W  = 16,
  parameter bit HAS_INV = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              inv_addr,
  input  logic              dir_en,
  input  logic              dir_val,
  input  logic              tag,
  input  logic              sz_en,
  input  logic              sz_val,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rnw,
  input  logic              bus_byte,
  output logic              hit
);
  logic addr_eq;
  logic addr_ok;
  logic dir_ok;
  logic size_ok;
  logic hit_d;
  logic hit_q;

  always_comb begin
    addr_eq = (bus_addr == ref_addr);
    addr_ok = (HAS_INV && inv_addr) ? ~addr_eq : addr_eq;
    dir_ok  = ~dir_en | (dir_val == bus_rnw);
    size_ok = tag | ~sz_en | (sz_val == bus_byte);
    hit_d   = bus_valid & en & addr_ok & dir_ok & size_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

  assign hit = hit_q;

  // R6
  hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(en && bus_valid));

  // R8
  hit_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && $past(dir_en)) |-> $past(bus_rnw == dir_val));

  // R9
  hit_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && $past(sz_en && !tag)) |-> $past(bus_byte == sz_val));
endmodule

// File: rtl/dbg_cmp_bank.sv
module dbg_cmp_bank
  import dbg_cmp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             reg_addr,
  input  logic                   reg_wr,
  input  logic [CTL_W-1:0]       reg_wdata,
  input  logic [SEL_W-1:0]       bank_sel,
  output logic [CTL_W-1:0]       reg_rdata,
  input  logic                   armed,
  input  logic [NCMP*ADDR_W-1:0] cmp_ref,
  input  logic                   bus_valid,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_rnw,
  input  logic                   bus_byte,
  output logic [NCMP-1:0]        match
);
  logic     rst_n_i;
  logic     win_hit;
  cmp_ctl_t ctl [NCMP];

  dbg_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_i)
  );

  assign win_hit = (reg_addr == CTL_OFFSET);

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    localparam bit HAS_INV = (i < NDB_CNT);
    logic wr_sel;

    assign wr_sel = reg_wr & win_hit & (bank_sel == SEL_W'(i));

    dbg_cmp_ctl_reg #(.HAS_INV(HAS_INV)) u_ctl (
      .clk   (clk),
      .rst_n (rst_n_i),
      .wr_sel(wr_sel),
      .armed (armed),
      .wdata (reg_wdata),
      .ctl   (ctl[i])
    );

    dbg_cmp_match #(.ADDR_W(ADDR_W), .HAS_INV(HAS_INV)) u_match (
      .clk      (clk),
      .rst_n    (rst_n_i),
      .en       (ctl[i].en),
      .inv_addr (ctl[i].inv_addr),
      .dir_en   (ctl[i].dir_en),
      .dir_val  (ctl[i].dir_val),
      .tag      (ctl[i].tag),
      .sz_en    (ctl[i].sz_en),
      .sz_val   (ctl[i].sz_val),
      .ref_addr (cmp_ref[i*ADDR_W +: ADDR_W]),
      .bus_valid(bus_valid),
      .bus_addr (bus_addr),
      .bus_rnw  (bus_rnw),
      .bus_byte (bus_byte),
      .hit      (match[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NCMP; i++) begin
      if (win_hit && bank_sel == SEL_W'(i)) reg_rdata = ctl[i];
    end
  end

  // R4
  empty_bank_read_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (bank_sel == 2'b11) |-> (reg_rdata == '0));
endmodule

// File: tb/dbg_cmp_bank_bench.sv
`timescale 1ns/1ps
module dbg_cmp_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [1:0]  bank_sel;
  logic [7:0]  reg_rdata;
  logic        armed;
  logic [47:0] cmp_ref;
  logic        bus_valid;
  logic [15:0] bus_addr;
  logic        bus_rnw;
  logic        bus_byte;
  logic [2:0]  match;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbg_cmp_bank u_dbg_cmp_bank (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .bank_sel(bank_sel), .reg_rdata(reg_rdata),
    .armed(armed), .cmp_ref(cmp_ref), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_rnw(bus_rnw), .bus_byte(bus_byte),
    .match(match)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] data,
                        input logic [7:0] off = 8'h28);
    @(negedge clk);
    reg_addr = off; bank_sel = sel; reg_wdata = data; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h28;
  endtask

  task automatic rd_chk(input logic [1:0] sel, input logic [7:0] exp, input string req,
                        input logic [7:0] off = 8'h28);
    @(negedge clk);
    reg_addr = off; bank_sel = sel;
    #2;
    chk(reg_rdata == exp, req, reg_rdata, exp);
    reg_addr = 8'h28;
  endtask

  task automatic access(input logic [15:0] a, input logic rnw, input logic byt,
                        input logic [2:0] exp, input string req);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_rnw = rnw; bus_byte = byt;
    @(negedge clk);
    bus_valid = 1'b0;
    chk(match == exp, req, match, exp);
    @(negedge clk);
    chk(match == 3'b000, {req, " pulse width"}, match, 0);
  endtask

  task automatic t_reset;
    rd_chk(2'd0, 8'h00, "R1 A reset");
    rd_chk(2'd1, 8'h00, "R1 B reset");
    rd_chk(2'd2, 8'h00, "R1 C reset");
    access(16'h1000, 1'b1, 1'b0, 3'b000, "R1 no match after reset");
  endtask

  task automatic t_window;
    wr_reg(2'd0, 8'hA4);
    wr_reg(2'd1, 8'h5A);
    wr_reg(2'd2, 8'hFF);
    rd_chk(2'd0, 8'hA4, "R2 A readback");
    rd_chk(2'd1, 8'h5A, "R2 B readback");
    rd_chk(2'd2, 8'hFD, "R5 C bit1 reads 0");
    wr_reg(2'd0, 8'h00, 8'h29);
    rd_chk(2'd0, 8'hA4, "R2 other offset write ignored");
    rd_chk(2'd0, 8'h00, "R2 other offset reads 0", 8'h29);
  endtask

  task automatic t_empty_bank;
    wr_reg(2'd3, 8'hFF);
    rd_chk(2'd3, 8'h00, "R4 select 11 reads 0");
    rd_chk(2'd0, 8'hA4, "R4 A untouched");
    rd_chk(2'd1, 8'h5A, "R4 B untouched");
    rd_chk(2'd2, 8'hFD, "R4 C untouched");
  endtask

  task automatic t_lock;
    @(negedge clk); armed = 1'b1;
    wr_reg(2'd0, 8'h11);
    @(negedge clk); armed = 1'b0;
    rd_chk(2'd0, 8'hA4, "R3 armed write dropped");
    wr_reg(2'd0, 8'h11);
    rd_chk(2'd0, 8'h11, "R3 disarmed write stored");
  endtask

  task automatic t_enable;
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd0, 8'h01);
    access(16'h1000, 1'b1, 1'b1, 3'b001, "R6 A equal address");
    access(16'h1002, 1'b1, 1'b1, 3'b000, "R6 A other address");
    wr_reg(2'd0, 8'h00);
    access(16'h1000, 1'b1, 1'b1, 3'b000, "R6 A disabled");
  endtask

  task automatic t_invert;
    wr_reg(2'd0, 8'h03);
    access(16'h1002, 1'b0, 1'b0, 3'b001, "R7 A inverted mismatch hits");
    access(16'h1000, 1'b0, 1'b0, 3'b000, "R7 A inverted equal misses");
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd2, 8'h03);
    access(16'h3000, 1'b0, 1'b0, 3'b100, "R5 C plain equality");
    access(16'h3002, 1'b0, 1'b0, 3'b000, "R5 C no inversion");
    wr_reg(2'd2, 8'h00);
  endtask

  task automatic t_dir;
    wr_reg(2'd1, 8'h0D);
    access(16'h2000, 1'b1, 1'b0, 3'b010, "R8 read matches");
    access(16'h2000, 1'b0, 1'b0, 3'b000, "R8 write rejected");
    wr_reg(2'd1, 8'h05);
    access(16'h2000, 1'b0, 1'b0, 3'b010, "R8 write matches");
    wr_reg(2'd1, 8'h09);
    access(16'h2000, 1'b0, 1'b0, 3'b010, "R8 direction ignored");
  endtask

  task automatic t_size;
    wr_reg(2'd1, 8'h81);
    access(16'h2000, 1'b1, 1'b0, 3'b010, "R9 word matches");
    access(16'h2000, 1'b1, 1'b1, 3'b000, "R9 byte rejected");
    wr_reg(2'd1, 8'hC1);
    access(16'h2000, 1'b1, 1'b1, 3'b010, "R9 byte matches");
    access(16'h2000, 1'b1, 1'b0, 3'b000, "R9 word rejected");
    wr_reg(2'd1, 8'h41);
    access(16'h2000, 1'b1, 1'b0, 3'b010, "R9 size ignored word");
    access(16'h2000, 1'b1, 1'b1, 3'b010, "R9 size ignored byte");
  endtask

  task automatic t_tag;
    wr_reg(2'd1, 8'hA1);
    access(16'h2000, 1'b1, 1'b1, 3'b010, "R10 tag overrides word size");
    wr_reg(2'd1, 8'hE1);
    access(16'h2000, 1'b1, 1'b0, 3'b010, "R10 tag overrides byte size");
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = 8'h28; reg_wr = 1'b0; reg_wdata = 8'h00;
    bank_sel = 2'd0; armed = 1'b0; cmp_ref = {16'h3000, 16'h2000, 16'h1000};
    bus_valid = 1'b0; bus_addr = 16'h0; bus_rnw = 1'b0; bus_byte = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_window();
    t_empty_bank();
    t_lock();
    t_enable();
    t_invert();
    t_dir();
    t_size();
    t_tag();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule